// File: doc/BRIEF.md
# Bootstrap SRAM Copy Engine

This block keeps a short boot program in a small retained SRAM that stays powered through sleep. On request it copies a run of words from that SRAM to a processor's instruction memory. A host reaches the SRAM and a handful of configuration registers through a simple 32-bit register bus. The host fills the SRAM and sets a source offset, a destination byte address and a word count. It then sets the run bit in the control register. The engine writes one word per clock on its destination port. The run bit drops back to zero when the last word is out, so the host can poll it.

A second control bit arms automatic replay. While it is set, every single-cycle power-up pulse repeats the same copy with whatever source, destination and count are programmed at that time. The host takes no part in the replay. The SRAM contents survive reset, so a replay after a reset needs only the registers to be reprogrammed.

Top module: `bsm_copy_top`

## Requirements
- R1: The register window uses these byte offsets. 0x000 is control: bit 31 is run/busy and bit 30 is auto-replay enable. 0x004 is the source byte offset; bits [9:2] hold the word index and read back with all other bits zero. 0x008 is the 32-bit destination byte address. 0x00C is the 32-bit word count. 0x010 is status, with bit 0 meaning done. Other offsets read zero. Read data appears on bus_rdata_o in the cycle after bus_re_i is sampled high.
- R2: Any address with bit 11 set reaches the 256-word retained SRAM. Address bits [9:2] select the word. Host writes and reads there move whole 32-bit words.
- R3: A control write with bit 31 set, while the engine is idle, starts a copy. Bit 31 then reads 1 until the copy ends and 0 afterwards. Status done reads 0 while the copy runs and 1 once it has ended.
- R4: For a copy of n words, the destination port writes word k (k = 0..n-1), taken from SRAM index src+k, to address dst+4k. The writes come on n consecutive clocks, and the first comes one cycle after the start is accepted. Busy falls, and done rises, one cycle after the last write.
- R5: With bit 30 set, a power-up pulse while idle starts the same copy as a host start. With bit 30 clear, a pulse has no effect.
- R6: A start with an effective count of zero makes no destination write. It leaves busy at 0 and sets done in the next cycle.
- R7: The effective count is the smaller of the count register and (256 − source word index).
- R8: While a copy runs, writes to the source, destination and count registers are dropped. Start requests and power-up pulses are ignored.
- R9: Reset clears control, status, source, destination and count. It leaves the SRAM contents as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register/SRAM write strobe |
| bus_re_i | input | 1 | Register/SRAM read strobe |
| bus_addr_i | input | 12 | Byte address within the block window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| pwr_up_i | input | 1 | Single-cycle power-up event |
| mem_we_o | output | 1 | Destination write strobe |
| mem_addr_o | output | 32 | Destination byte address |
| mem_wdata_o | output | 32 | Destination write data |

## Verification
The copy path is driven with a full-length copy from offset zero, a short copy from a non-zero offset, a zero count, and a copy that runs past the end of the SRAM. Together these separate errors in address stepping, in source indexing, in the empty case and in the clamp. Replay is tried with the enable clear and then set. This shows that the pulse is gated by the enable rather than by the start bit. During a running copy, configuration writes, a second start and a pulse are applied, and the registers are read back afterwards. A reset in mid-copy, followed by SRAM readback, separates register clearing from memory retention.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam logic [11:0] OFF_CTRL = 12'h000;
  localparam logic [11:0] OFF_SRC  = 12'h004;
  localparam logic [11:0] OFF_DST  = 12'h008;
  localparam logic [11:0] OFF_CNT  = 12'h00C;
  localparam logic [11:0] OFF_STAT = 12'h010;
  localparam int CTRL_RUN_BIT = 31;
  localparam int CTRL_EN_BIT  = 30;
endpackage

// File: rtl/bsm_sram.sv
module bsm_sram #(
  parameter int WORDS = 256,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [31:0]      wdata_i,
  input  logic [IDX_W-1:0] host_raddr_i,
  output logic [31:0]      host_rdata_o,
  input  logic [IDX_W-1:0] eng_raddr_i,
  output logic [31:0]      eng_rdata_o
);
  logic [31:0] mem_q [WORDS];

  // storage is never reset: contents survive rst_ni
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    host_rdata_o <= mem_q[host_raddr_i];
    eng_rdata_o  <= mem_q[eng_raddr_i];
  end
endmodule

// File: rtl/bsm_regs.sv
module bsm_regs
  import bsm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic              pwr_up_i,
  input  logic              busy_i,
  output logic [IDX_W-1:0]  src_o,
  output logic [31:0]       dst_o,
  output logic [31:0]       cnt_o,
  output logic              en_o,
  output logic              start_o
);
  logic [IDX_W-1:0] src_q;
  logic [31:0]      dst_q, cnt_q;
  logic             en_q;
  logic             wr_ctrl, wr_src, wr_dst, wr_cnt;

  always_comb begin
    wr_ctrl = bus_we_i && (bus_addr_i == ADDR_W'(OFF_CTRL));
    wr_src  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_SRC));
    wr_dst  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_DST));
    wr_cnt  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_CNT));
    start_o = !busy_i && ((wr_ctrl && bus_wdata_i[CTRL_RUN_BIT]) || (pwr_up_i && en_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= bus_wdata_i[CTRL_EN_BIT];
      if (!busy_i) begin
        if (wr_src) src_q <= bus_wdata_i[IDX_W+1:2];
        if (wr_dst) dst_q <= bus_wdata_i;
        if (wr_cnt) cnt_q <= bus_wdata_i;
      end
    end
  end

  assign src_o = src_q;
  assign dst_o = dst_q;
  assign cnt_o = cnt_q;
  assign en_o  = en_q;

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(src_q) && $stable(dst_q) && $stable(cnt_q)); // R8
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !start_o); // R8
endmodule

// File: rtl/bsm_copy_seq.sv
module bsm_copy_seq #(
  parameter int WORDS = 256,
  parameter int IDX_W = $clog2(WORDS),
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] src_i,
  input  logic [31:0]      dst_i,
  input  logic [31:0]      cnt_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic [31:0]      rd_data_i,
  output logic             mem_we_o,
  output logic [31:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o
);
  localparam logic [CNT_W-1:0] WORDS_C = CNT_W'(WORDS);

  logic             busy_q, done_q, wr_v_q;
  logic [IDX_W-1:0] src_q;
  logic [31:0]      dst_q;
  logic [CNT_W-1:0] eff_q, rd_cnt_q, wr_idx_q;
  logic [CNT_W-1:0] room, eff;
  logic             rd_act, last_wr;

  always_comb begin
    room    = WORDS_C - {1'b0, src_i};
    eff     = (cnt_i > {{(32-CNT_W){1'b0}}, room}) ? room : cnt_i[CNT_W-1:0];
    rd_act  = busy_q && (rd_cnt_q < eff_q);
    last_wr = wr_v_q && (wr_idx_q == eff_q - CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      wr_v_q   <= 1'b0;
      src_q    <= '0;
      dst_q    <= '0;
      eff_q    <= '0;
      rd_cnt_q <= '0;
      wr_idx_q <= '0;
    end else if (start_i) begin
      src_q    <= src_i;
      dst_q    <= dst_i;
      eff_q    <= eff;
      rd_cnt_q <= '0;
      wr_v_q   <= 1'b0;
      busy_q   <= (eff != '0);
      done_q   <= (eff == '0);
    end else begin
      // read runs one cycle ahead of the write
      wr_v_q   <= rd_act;
      wr_idx_q <= rd_cnt_q;
      if (rd_act) rd_cnt_q <= rd_cnt_q + CNT_W'(1);
      if (last_wr) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign rd_idx_o    = src_q + rd_cnt_q[IDX_W-1:0];
  assign mem_we_o    = wr_v_q;
  assign mem_addr_o  = dst_q + {{(30-CNT_W){1'b0}}, wr_idx_q, 2'b00};
  assign mem_wdata_o = rd_data_i;

  AST_WR_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_q); // R4
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && $past(mem_we_o) |-> mem_addr_o == $past(mem_addr_o) + 32'd4); // R4
  AST_ZERO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (eff == '0) |=> done_q && !busy_q && !mem_we_o); // R6
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !done_q); // R3
  AST_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> 32'(src_q) + 32'(eff_q) <= 32'(WORDS)); // R7
endmodule

// File: rtl/bsm_copy_top.sv
module bsm_copy_top
  import bsm_pkg::*;
#(
  parameter int SRAM_WORDS = 256,
  parameter int ADDR_W     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              pwr_up_i,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o
);
  localparam int IDX_W = $clog2(SRAM_WORDS);
  localparam int CNT_W = IDX_W + 1;

  logic             sram_hit, start, busy, done, en;
  logic [IDX_W-1:0] src, eng_idx;
  logic [31:0]      dst, cnt, host_rdata, eng_rdata, reg_rdata, reg_rdata_q;
  logic             rd_sram_q;

  assign sram_hit = bus_addr_i[ADDR_W-1];

  bsm_sram #(.WORDS(SRAM_WORDS), .IDX_W(IDX_W)) u_sram (
    .clk_i        (clk_i),
    .we_i         (bus_we_i && sram_hit),
    .waddr_i      (bus_addr_i[IDX_W+1:2]),
    .wdata_i      (bus_wdata_i),
    .host_raddr_i (bus_addr_i[IDX_W+1:2]),
    .host_rdata_o (host_rdata),
    .eng_raddr_i  (eng_idx),
    .eng_rdata_o  (eng_rdata)
  );

  bsm_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .pwr_up_i    (pwr_up_i),
    .busy_i      (busy),
    .src_o       (src),
    .dst_o       (dst),
    .cnt_o       (cnt),
    .en_o        (en),
    .start_o     (start)
  );

  bsm_copy_seq #(.WORDS(SRAM_WORDS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .src_i       (src),
    .dst_i       (dst),
    .cnt_i       (cnt),
    .busy_o      (busy),
    .done_o      (done),
    .rd_idx_o    (eng_idx),
    .rd_data_i   (eng_rdata),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      ADDR_W'(OFF_CTRL): reg_rdata = {busy, en, 30'b0};
      ADDR_W'(OFF_SRC):  reg_rdata = {{(30-IDX_W){1'b0}}, src, 2'b00};
      ADDR_W'(OFF_DST):  reg_rdata = dst;
      ADDR_W'(OFF_CNT):  reg_rdata = cnt;
      ADDR_W'(OFF_STAT): reg_rdata = {31'b0, done};
      default:           reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rdata_q <= '0;
      rd_sram_q   <= 1'b0;
    end else if (bus_re_i) begin
      reg_rdata_q <= reg_rdata;
      rd_sram_q   <= sram_hit;
    end
  end

  assign bus_rdata_o = rd_sram_q ? host_rdata : reg_rdata_q;

  AST_RUN_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(start)); // R3
endmodule

// File: tb/bsm_copy_top_tb.sv
module bsm_copy_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0, pwr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, mem_addr, mem_wdata;
  logic        mem_we;

  int    n_vec = 0, n_bad = 0;
  string cur_req = "R9";

  always #4 clk = ~clk;

  bsm_copy_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_re_i(bus_re),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .pwr_up_i(pwr), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  // behavioural reference
  logic [31:0] m_sram [256];
  logic        m_busy = 0, m_done = 0, m_en = 0, e_rv = 0;
  int          m_src = 0, m_k = 0, m_n = 0;
  logic [31:0] m_dst = 0, m_cnt = 0, e_rdata = 0;
  int          r_src = 0;
  logic [31:0] r_dst = 0;

  function automatic logic [31:0] m_read(input logic [11:0] a);
    if (a[11]) return m_sram[a[9:2]];
    case (a)
      12'h000: return {m_busy, m_en, 30'b0};
      12'h004: return 32'(m_src) << 2;
      12'h008: return m_dst;
      12'h00C: return m_cnt;
      12'h010: return {31'b0, m_done};
      default: return 32'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic st;
    longint room;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_en = 0; m_src = 0; m_dst = 0; m_cnt = 0;
      m_k = 0; m_n = 0; e_rv = 0; e_rdata = 0;
    end else begin
      e_rv = bus_re;
      if (bus_re) e_rdata = m_read(bus_addr);
      if (m_busy) begin
        m_k++;
        if (m_k == m_n + 1) begin m_busy = 0; m_done = 1; end
        if (bus_we && bus_addr == 12'h000) m_en = bus_wdata[30];
      end else begin
        st = (bus_we && bus_addr == 12'h000 && bus_wdata[31]) || (pwr && m_en);
        if (st) begin
          room = 256 - m_src;
          m_n = (longint'(m_cnt) > room) ? int'(room) : int'(m_cnt);
          r_src = m_src; r_dst = m_dst; m_k = 0;
          m_busy = (m_n != 0); m_done = (m_n == 0);
        end
        if (bus_we && bus_addr == 12'h000) m_en = bus_wdata[30];
        if (bus_we && bus_addr == 12'h004) m_src = int'(bus_wdata[9:2]);
        if (bus_we && bus_addr == 12'h008) m_dst = bus_wdata;
        if (bus_we && bus_addr == 12'h00C) m_cnt = bus_wdata;
      end
      if (bus_we && bus_addr[11]) m_sram[bus_addr[9:2]] = bus_wdata;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare every clock, away from the edge
  always @(posedge clk) begin
    logic ewe;
    #2;
    ewe = m_busy && m_k >= 1 && m_k <= m_n;
    chk("mem_we", {31'b0, mem_we}, {31'b0, ewe});
    if (ewe) begin
      chk("mem_addr", mem_addr, r_dst + 32'(4 * (m_k - 1)));
      chk("mem_wdata", mem_wdata, m_sram[r_src + m_k - 1]);
    end
    if (e_rv) chk("rdata", bus_rdata, e_rdata);
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask
  task automatic rd(input logic [11:0] a);
    @(negedge clk); bus_re = 1; bus_addr = a;
    @(negedge clk); bus_re = 0;
  endtask
  task automatic pulse();
    @(negedge clk); pwr = 1;
    @(negedge clk); pwr = 0;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 2000 && m_busy; i++) @(negedge clk);
  endtask
  task automatic read_all();
    rd(12'h000); rd(12'h004); rd(12'h008); rd(12'h00C); rd(12'h010);
  endtask
  task automatic copy(input int src, input logic [31:0] dst, input logic [31:0] cnt);
    wr(12'h004, 32'(src) << 2); wr(12'h008, dst); wr(12'h00C, cnt);
    wr(12'h000, 32'h8000_0000);
    rd(12'h000); rd(12'h010);
    wait_idle();
    rd(12'h000); rd(12'h010);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_sram[i] = 'x;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R9"; read_all();
    cur_req = "R1"; rd(12'h014); rd(12'h7FC);
    cur_req = "R2";
    for (int i = 0; i < 256; i++) wr(12'h800 + 12'(i * 4), 32'hA500_0000 ^ (32'(i) * 32'h0101_0101));
    rd(12'h800); rd(12'h9FC); rd(12'hBFC);
    cur_req = "R3"; copy(0, 32'h0000_1000, 32'd8);
    cur_req = "R4"; copy(4, 32'h0002_0040, 32'd5);
    cur_req = "R4"; copy(0, 32'h0003_0000, 32'd256);
    cur_req = "R6"; copy(9, 32'h0004_0000, 32'd0);
    cur_req = "R7"; copy(252, 32'h0005_0000, 32'd10);
    cur_req = "R7"; copy(10, 32'h0005_8000, 32'hFFFF_FFFF);
    cur_req = "R1"; read_all();
    cur_req = "R8";
    wr(12'h004, 32'h0000_0008); wr(12'h008, 32'h0006_0000); wr(12'h00C, 32'd20);
    wr(12'h000, 32'h8000_0000);
    wr(12'h004, 32'h0000_0100); wr(12'h008, 32'hDEAD_0000); wr(12'h00C, 32'd3);
    wr(12'h000, 32'hC000_0000); pulse();
    read_all(); wait_idle(); read_all();
    cur_req = "R5";
    wr(12'h000, 32'h0000_0000); wr(12'h00C, 32'd6); pulse(); repeat (10) @(negedge clk); read_all();
    wr(12'h000, 32'h4000_0000); pulse(); rd(12'h000); wait_idle(); read_all();
    pulse(); wait_idle(); read_all();
    cur_req = "R9";
    wr(12'h00C, 32'd40); wr(12'h000, 32'hC000_0000); repeat (5) @(negedge clk);
    rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
    read_all(); rd(12'h800); rd(12'h828); rd(12'hBFC);
    pulse(); repeat (4) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule